// File: doc/BRIEF.md
# Floating-Point Conditional Move Unit

This unit executes the conditional-assignment group of a floating-point processor's instruction set. Each operation carries a data operand (`op_in1`), a test operand (`op_in2`), a destination tag and a 5-bit opcode. One cycle later the unit presents the data operand, the tag and a write-enable. The write-enable is high only when the predicate that the opcode selects holds for the test operand. When the predicate fails, the write-enable stays low, so the register file keeps the value it already has at that destination.

The predicates never compare numbers. Each one looks only at the raw sign, exponent and significand fields of the test operand. A sign test therefore accepts a NaN whose sign bit is clear. The zero test ignores the sign, and the NaN and infinity classes are each paired with their exact logical complement. A parameter selects single precision (8-bit exponent, 23-bit significand) or double precision (11-bit exponent, 52-bit significand).

The unit is fully pipelined and takes a new operation on every cycle. Any opcode outside the conditional group is dropped, and nothing appears at the output for it. Opcode encoding: bits [4:3] = `2'b10` mark the group. Bits [2:1] pick the field class: `00` sign, `01` zero, `10` NaN, `11` infinity. Bit [0] inverts the test. This gives 10000 positive, 10001 negative, 10010 zero, 10011 non-zero, 10100 NaN, 10101 not-NaN, 10110 infinity and 10111 not-infinity.

Top module: `fp_cmov_unit`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after its release, `res_valid` and `res_we` are 0.
- R2: An operation accepted with `op_valid`=1 and an opcode in 10000..10111 gives `res_valid`=1 exactly one clock later, with `res_data` equal to that operation's `op_in1` and `res_tag` equal to its `op_tag`. Operations may arrive on consecutive cycles. `res_we` is never high without `res_valid`.
- R3: Opcode 10000 writes when the sign bit of `op_in2` is 0, and opcode 10001 writes when it is 1. NaN status is ignored, so a positive NaN passes 10000.
- R4: Opcode 10010 writes when the exponent and the significand of `op_in2` are both zero, whatever the sign (negative zero passes). Opcode 10011 writes when either field is non-zero.
- R5: Opcode 10100 writes when the exponent is all ones and the significand is non-zero. Opcode 10101 writes in every other case.
- R6: Opcode 10110 writes when the exponent is all ones and the significand is zero. Opcode 10111 writes in every other case.
- R7: When `op_valid` is 0, or the opcode lies outside 10000..10111, `res_valid` and `res_we` are 0 on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_valid | input | 1 | An operation is presented this cycle |
| op_code | input | 5 | Opcode of the operation |
| op_in1 | input | DATA_W (32 or 64) | Data operand to be moved |
| op_in2 | input | DATA_W | Test operand examined by the predicate |
| op_tag | input | TAG_W | Destination tag |
| res_valid | output | 1 | A conditional operation completed |
| res_we | output | 1 | Predicate held; write `res_data` to `res_tag` |
| res_data | output | DATA_W | Data operand of the completed operation |
| res_tag | output | TAG_W | Destination tag of the completed operation |

## Verification
The unit holds only one stage of registers, so a wrong internal value shows at the ports on the very next cycle. A predicate fault shows as `res_we` taking the wrong value for a particular class of `op_in2`. A broken capture path shows as `res_data` or `res_tag` belonging to a neighbouring operation. For that reason the stimulus is issued back to back and mixes all eight opcodes. It also sits on the field boundaries: negative zero, denormals, the largest finite exponent, infinities of both signs, and NaNs of both signs. A single wrong bit in the class or opcode decode therefore flips `res_we` on at least one vector.

// File: rtl/fcm_pkg.sv
package fcm_pkg;

    typedef enum logic [4:0] {
        OPC_POSITIVE = 5'b10000,
        OPC_NEGATIVE = 5'b10001,
        OPC_ZERO     = 5'b10010,
        OPC_NONZERO  = 5'b10011,
        OPC_NAN      = 5'b10100,
        OPC_NOTNAN   = 5'b10101,
        OPC_INF      = 5'b10110,
        OPC_NOTINF   = 5'b10111
    } fcm_opc_e;

    typedef enum logic [1:0] {
        CLS_SIGN = 2'b00,
        CLS_ZERO = 2'b01,
        CLS_NAN  = 2'b10,
        CLS_INF  = 2'b11
    } fcm_sel_e;

    typedef struct packed {
        logic sign;
        logic zero;
        logic nan;
        logic inf;
    } fcm_class_t;

    localparam logic [1:0] GROUP_BITS = 2'b10;

endpackage

// File: rtl/fcm_classify.sv
module fcm_classify
    import fcm_pkg::*;
#(
    parameter int EXP_W = 8,
    parameter int SIG_W = 23,
    localparam int DATA_W = 1 + EXP_W + SIG_W
) (
    input  logic [DATA_W-1:0] operand,
    output fcm_class_t        cls
);

    logic [EXP_W-1:0] exp_field;
    logic [SIG_W-1:0] sig_field;
    logic             exp_ones;
    logic             exp_zero;
    logic             sig_zero;

    always_comb begin
        exp_field = operand[DATA_W-2 -: EXP_W];
        sig_field = operand[SIG_W-1:0];
        exp_ones  = &exp_field;
        exp_zero  = ~|exp_field;
        sig_zero  = ~|sig_field;
        cls.sign  = operand[DATA_W-1];
        cls.zero  = exp_zero & sig_zero;
        cls.nan   = exp_ones & ~sig_zero;
        cls.inf   = exp_ones & sig_zero;
    end

endmodule

// File: rtl/fcm_predicate.sv
module fcm_predicate
    import fcm_pkg::*;
(
    input  logic [4:0]  opcode,
    input  fcm_class_t  cls,
    output logic        legal,
    output logic        hit
);

    fcm_sel_e sel;
    logic     base;

    always_comb begin
        legal = (opcode[4:3] == GROUP_BITS);
        sel   = fcm_sel_e'(opcode[2:1]);
        unique case (sel)
            CLS_SIGN: base = ~cls.sign;
            CLS_ZERO: base = cls.zero;
            CLS_NAN:  base = cls.nan;
            CLS_INF:  base = cls.inf;
            default:  base = 1'b0;
        endcase
        hit = legal & (base ^ opcode[0]);
    end

endmodule

// File: rtl/fcm_out_stage.sv
module fcm_out_stage #(
    parameter int DATA_W = 32,
    parameter int TAG_W  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              take,
    input  logic              hit,
    input  logic [DATA_W-1:0] data_in,
    input  logic [TAG_W-1:0]  tag_in,
    output logic              res_valid,
    output logic              res_we,
    output logic [DATA_W-1:0] res_data,
    output logic [TAG_W-1:0]  res_tag
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            res_valid <= 1'b0;
            res_we    <= 1'b0;
        end else begin
            res_valid <= take;
            res_we    <= take & hit;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            res_data <= '0;
            res_tag  <= '0;
        end else if (take) begin
            res_data <= data_in;
            res_tag  <= tag_in;
        end
    end

endmodule

// File: rtl/fp_cmov_unit.sv
module fp_cmov_unit
    import fcm_pkg::*;
#(
    parameter bit DOUBLE_PREC = 1'b0,
    parameter int TAG_W       = 5,
    localparam int EXP_W      = DOUBLE_PREC ? 11 : 8,
    localparam int SIG_W      = DOUBLE_PREC ? 52 : 23,
    localparam int DATA_W     = 1 + EXP_W + SIG_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_valid,
    input  logic [4:0]        op_code,
    input  logic [DATA_W-1:0] op_in1,
    input  logic [DATA_W-1:0] op_in2,
    input  logic [TAG_W-1:0]  op_tag,
    output logic              res_valid,
    output logic              res_we,
    output logic [DATA_W-1:0] res_data,
    output logic [TAG_W-1:0]  res_tag
);

    fcm_class_t test_cls;
    logic       code_legal;
    logic       pred_hit;
    logic       take;

    fcm_classify #(
        .EXP_W (EXP_W),
        .SIG_W (SIG_W)
    ) classify_i (
        .operand (op_in2),
        .cls     (test_cls)
    );

    fcm_predicate predicate_i (
        .opcode (op_code),
        .cls    (test_cls),
        .legal  (code_legal),
        .hit    (pred_hit)
    );

    assign take = op_valid & code_legal;

    fcm_out_stage #(
        .DATA_W (DATA_W),
        .TAG_W  (TAG_W)
    ) out_stage_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .take      (take),
        .hit       (pred_hit),
        .data_in   (op_in1),
        .tag_in    (op_tag),
        .res_valid (res_valid),
        .res_we    (res_we),
        .res_data  (res_data),
        .res_tag   (res_tag)
    );

endmodule

// File: rtl/fcm_chk.sv
module fcm_chk
    import fcm_pkg::*;
#(
    parameter int EXP_W  = 8,
    parameter int SIG_W  = 23,
    parameter int TAG_W  = 5,
    localparam int DATA_W = 1 + EXP_W + SIG_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic              op_valid,
    input logic [4:0]        op_code,
    input logic [DATA_W-1:0] op_in1,
    input logic [DATA_W-1:0] op_in2,
    input logic [TAG_W-1:0]  op_tag,
    input logic              res_valid,
    input logic              res_we,
    input logic [DATA_W-1:0] res_data,
    input logic [TAG_W-1:0]  res_tag
);

    logic in_group;
    logic exp_all_ones;
    logic sig_nonzero;

    assign in_group     = op_valid && (op_code[4:3] == 2'b10);
    assign exp_all_ones = &op_in2[DATA_W-2 -: EXP_W];
    assign sig_nonzero  = |op_in2[SIG_W-1:0];

    // R1
    always @(negedge clk) begin
        if (!rst_n) begin
            reset_quiet_chk: assert (!res_valid && !res_we);
        end
    end

    // R2
    accept_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_group |=> (res_valid && res_data == $past(op_in1) && res_tag == $past(op_tag)));

    // R2
    we_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        res_we |-> res_valid);

    // R7
    reject_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_group |=> (!res_valid && !res_we));

    // R3
    sign_test_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_code == OPC_POSITIVE) |=> (res_we == !$past(op_in2[DATA_W-1])));

    // R4
    zero_test_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_code == OPC_ZERO) |=> (res_we == ($past(op_in2[DATA_W-2:0]) == '0)));

    // R5
    nan_test_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_code == OPC_NOTNAN) |=> (res_we == !$past(exp_all_ones && sig_nonzero)));

    // R6
    inf_test_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_code == OPC_INF) |=> (res_we == $past(exp_all_ones && !sig_nonzero)));

endmodule

bind fp_cmov_unit fcm_chk #(
    .EXP_W (EXP_W),
    .SIG_W (SIG_W),
    .TAG_W (TAG_W)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .op_valid  (op_valid),
    .op_code   (op_code),
    .op_in1    (op_in1),
    .op_in2    (op_in2),
    .op_tag    (op_tag),
    .res_valid (res_valid),
    .res_we    (res_we),
    .res_data  (res_data),
    .res_tag   (res_tag)
);

// File: tb/fp_cmov_unit_tb_top.sv
module fp_cmov_unit_tb_top;

    localparam int TAG_W  = 5;
    localparam int DATA_W = 32;
    localparam int NVEC   = 18;

    // entry: {opcode[4:0], in2[31:0], expected write-enable}
    localparam logic [37:0] VEC [0:NVEC-1] = '{
        {5'b10000, 32'h7FC0_0000, 1'b1},  // R3 positive NaN passes
        {5'b10000, 32'h8000_0000, 1'b0},  // R3
        {5'b10001, 32'hFFC0_0001, 1'b1},  // R3
        {5'b10001, 32'h3F80_0000, 1'b0},  // R3
        {5'b10010, 32'h8000_0000, 1'b1},  // R4 negative zero
        {5'b10010, 32'h0000_0001, 1'b0},  // R4 denormal
        {5'b10010, 32'h0080_0000, 1'b0},  // R4
        {5'b10011, 32'h0000_0000, 1'b0},  // R4
        {5'b10011, 32'h0000_0001, 1'b1},  // R4
        {5'b10100, 32'h7FC0_0000, 1'b1},  // R5
        {5'b10100, 32'h7F80_0000, 1'b0},  // R5
        {5'b10100, 32'h7F7F_FFFF, 1'b0},  // R5
        {5'b10101, 32'hFFC0_0001, 1'b0},  // R5
        {5'b10101, 32'h7F80_0000, 1'b1},  // R5
        {5'b10110, 32'hFF80_0000, 1'b1},  // R6
        {5'b10110, 32'h7F80_0001, 1'b0},  // R6
        {5'b10111, 32'h7F80_0000, 1'b0},  // R6
        {5'b10111, 32'h7F80_0001, 1'b1}   // R6
    };

    logic              clk;
    logic              rst_n;
    logic              op_valid;
    logic [4:0]        op_code;
    logic [DATA_W-1:0] op_in1;
    logic [DATA_W-1:0] op_in2;
    logic [TAG_W-1:0]  op_tag;
    logic              res_valid;
    logic              res_we;
    logic [DATA_W-1:0] res_data;
    logic [TAG_W-1:0]  res_tag;

    int checks;
    int fails;

    fp_cmov_unit #(
        .DOUBLE_PREC (1'b0),
        .TAG_W       (TAG_W)
    ) dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .op_valid  (op_valid),
        .op_code   (op_code),
        .op_in1    (op_in1),
        .op_in2    (op_in2),
        .op_tag    (op_tag),
        .res_valid (res_valid),
        .res_we    (res_we),
        .res_data  (res_data),
        .res_tag   (res_tag)
    );

    initial clk = 1'b0;
    always #5 clk = ~clk;

    function automatic logic [DATA_W-1:0] data_of(input int idx);
        return 32'hA5000000 + DATA_W'(idx * 7);
    endfunction

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic check_result(input int idx, input logic exp_we);
        string req;
        case (VEC[idx][37:34])
            4'b1000: req = "R3";
            4'b1001: req = "R4";
            4'b1010: req = "R5";
            default: req = "R6";
        endcase
        check(req, {63'b0, res_we}, {63'b0, exp_we});
        check("R2 valid", {63'b0, res_valid}, 64'd1);
        check("R2 data", {32'b0, res_data}, {32'b0, data_of(idx)});
        check("R2 tag", {59'b0, res_tag}, {59'b0, TAG_W'(idx)});
    endtask

    initial begin
        #200000;
        fails++;
        checks++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        checks   = 0;
        fails    = 0;
        rst_n    = 1'b0;
        op_valid = 1'b0;
        op_code  = '0;
        op_in1   = '0;
        op_in2   = '0;
        op_tag   = '0;
        repeat (3) @(negedge clk);
        // R1: outputs quiet during reset
        check("R1 valid", {63'b0, res_valid}, 64'd0);
        check("R1 we", {63'b0, res_we}, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 valid after release", {63'b0, res_valid}, 64'd0);

        // back-to-back vector walk (R2..R6)
        for (int i = 0; i <= NVEC; i++) begin
            if (i > 0) check_result(i - 1, VEC[i-1][0]);
            if (i < NVEC) begin
                op_valid = 1'b1;
                op_code  = VEC[i][37:33];
                op_in2   = VEC[i][32:1];
                op_in1   = data_of(i);
                op_tag   = TAG_W'(i);
            end else begin
                op_valid = 1'b0;
            end
            @(negedge clk);
        end
        // R7: idle cycle after the walk
        check("R7 idle valid", {63'b0, res_valid}, 64'd0);

        // R7: opcode outside the group is dropped even with a passing test operand
        op_valid = 1'b1;
        op_code  = 5'b00011;
        op_in2   = 32'h0000_0000;
        op_in1   = 32'h1234_5678;
        @(negedge clk);
        check("R7 foreign valid", {63'b0, res_valid}, 64'd0);
        check("R7 foreign we", {63'b0, res_we}, 64'd0);
        op_code = 5'b11010;
        @(negedge clk);
        check("R7 high opcode we", {63'b0, res_we}, 64'd0);

        // R7: valid low with an in-group opcode
        op_valid = 1'b0;
        op_code  = 5'b10010;
        @(negedge clk);
        check("R7 invalid valid", {63'b0, res_valid}, 64'd0);
        check("R7 invalid we", {63'b0, res_we}, 64'd0);

        // R4: positive zero passes the zero test
        op_valid = 1'b1;
        op_code  = 5'b10010;
        op_in2   = 32'h0000_0000;
        op_in1   = 32'hCAFE_0001;
        op_tag   = 5'd31;
        @(negedge clk);
        check("R4 plus zero", {63'b0, res_we}, 64'd1);
        check("R2 tag max", {59'b0, res_tag}, 64'd31);

        // R3: negative infinity fails the positive test
        op_code = 5'b10000;
        op_in2  = 32'hFF80_0000;
        @(negedge clk);
        check("R3 minus inf", {63'b0, res_we}, 64'd0);

        // R1: reset in mid-stream clears the outputs
        op_code = 5'b10011;
        op_in2  = 32'h3F80_0000;
        #2 rst_n = 1'b0;
        @(negedge clk);
        check("R1 mid reset valid", {63'b0, res_valid}, 64'd0);
        check("R1 mid reset we", {63'b0, res_we}, 64'd0);
        op_valid = 1'b0;
        rst_n    = 1'b1;
        @(negedge clk);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule